// File: doc/BRIEF.md
# Three-Channel DMA Arbiter with Completion Interrupt Vector

This block stands between a set of DMA channels and the shared transfer path. Each cycle the path is idle, it looks at the channels that are asking to move a unit of data and grants exactly one of them. The order is either fixed, with the lowest channel number winning, or rotating, where the channel just served drops to the back of the queue. Software can switch between the two at any time. A granted transfer keeps the path for a fixed number of cycles and is followed by one idle cycle before the next grant.

The same block gathers the per-channel completion events. Each event sets a flag. The flags, masked by per-channel enables and a global enable, form one interrupt line. An even-valued 16-bit vector names the lowest-numbered pending channel, and a read strobe on that vector clears the flag it reported. The flags also drive a ring of chained triggers, so one channel finishing can start the next. A non-maskable event may cut a running transfer short only when the core allows it. Otherwise it is held off until the path is free.

Top module: `dma_arb_irq`

## Requirements
- R1: `grant` is one-hot or zero. A new grant goes only to a channel whose `ch_req` bit was high in the cycle before the grant appeared. The grant never moves to another channel while a transfer is running.
- R2: With `rr_en` low, the lowest-numbered requesting channel wins (channel 0 over 1 over 2).
- R3: With `rr_en` high, the channel after the one last granted has top priority, and the order wraps from 2 back to 0. The last-granted record is updated on every grant in either mode. After reset, channel 0 is first.
- R4: A grant lasts XFER_CYCLES (default 2) cycles. It is followed by exactly one cycle with `grant` zero, even if requests stay high.
- R5: A high `ch_done[i]` at a clock edge sets `flag_out[i]`. The flag stays set until a vector read clears it. If a set and a clear of the same flag happen together, the set wins.
- R6: `irq` is high exactly when `glb_ie` is high, some `flag_out[i] & ch_ie[i]` is set, and no grant is active.
- R7: `vec_out` is 16 bits. Only bits 3..1 are used. It reads 2*(i+1) for the lowest-numbered channel i with both flag and enable set (2, 4 or 6), and 0 when there is none. `glb_ie` does not affect it.
- R8: A clock edge with `vec_rd` high clears only the flag that `vec_out` reported. A read while `vec_out` is 0 changes no flag.
- R9: `chain_trig[i]` is high when `chain_sel[i]` is set and the flag of channel (i+2) mod 3 is set. This means 0 feeds 1, 1 feeds 2, and 2 feeds 0. Chaining never clears a flag.
- R10: `nmi_take` is `nmi_req` gated by (`nmi_en` or no active grant). When `nmi_req` and `nmi_en` are high during an active grant, the grant is dropped at the next edge. With `nmi_en` low, the transfer runs to its end.
- R11: During reset, `grant`, `flag_out`, `chain_trig`, `irq` and `vec_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_en | input | 1 | Rotating priority when high, fixed when low |
| ch_req | input | NCH | Per-channel transfer request |
| ch_done | input | NCH | Per-channel completion event (size count reached zero) |
| ch_ie | input | NCH | Per-channel interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| chain_sel | input | NCH | Per-channel select of the chained completion trigger |
| vec_rd | input | 1 | Vector read strobe, clears the reported flag |
| nmi_req | input | 1 | Non-maskable event request |
| nmi_en | input | 1 | Allow the non-maskable event to cut a transfer |
| grant | output | NCH | One-hot transfer grant |
| flag_out | output | NCH | Completion flags |
| chain_trig | output | NCH | Chained trigger to each channel |
| irq | output | 1 | Combined interrupt request |
| vec_out | output | 16 | Priority-encoded interrupt vector |
| nmi_take | output | 1 | Non-maskable event accepted now |

## Verification
The arbiter is driven with request masks from a single requester up to all three at once, in both priority modes. A run of repeated all-request patterns in rotating mode shows the pointer advancing 0, 1, 2 and wrapping. Sparse masks such as 101 and 011 show that the rotation skips idle channels instead of stalling on them. Raising new requests in the middle of a grant distinguishes a held grant from a re-arbitrating one. Back-to-back requests expose the idle gap. On the interrupt side, flag sets are combined with enable masks, the global enable, simultaneous set and read, and reads of an empty vector. These separate the flag state from the masking, and the clearing rule from the encoding.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  // Width of the interrupt vector word; codes sit at bit 1 upward.
  localparam int unsigned VEC_W   = 16;
  localparam int unsigned VEC_LSB = 1;
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NCH = 3,
  parameter int IW  = 2
) (
  input  logic           rr_en,
  input  logic [IW-1:0]  top_idx,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] sel_oh,
  output logic [IW-1:0]  sel_idx,
  output logic           sel_any
);
  logic [IW-1:0] base;
  logic [IW:0]   pos;

  assign base = rr_en ? top_idx : '0;

  // Walk from the lowest priority slot to the highest; the last hit wins.
  always_comb begin
    sel_any = 1'b0;
    sel_idx = '0;
    pos     = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      pos = {1'b0, base} + (IW+1)'(k);
      if (pos >= (IW+1)'(NCH)) pos = pos - (IW+1)'(NCH);
      if (req[pos[IW-1:0]]) begin
        sel_any = 1'b1;
        sel_idx = pos[IW-1:0];
      end
    end
  end

  assign sel_oh = sel_any ? (NCH'(1) << sel_idx) : '0;
endmodule

// File: rtl/dma_arb_seq.sv
module dma_arb_seq #(
  parameter int NCH         = 3,
  parameter int IW          = 2,
  parameter int XFER_CYCLES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_any,
  input  logic [NCH-1:0] sel_oh,
  input  logic [IW-1:0]  sel_idx,
  input  logic           abort,
  output logic [NCH-1:0] grant,
  output logic [IW-1:0]  top_idx,
  output logic           busy
);
  localparam int CW = $clog2(XFER_CYCLES + 1);

  logic [CW-1:0]  cnt_q, cnt_d;
  logic [NCH-1:0] grant_q, grant_d;
  logic [IW-1:0]  top_q, top_d;
  logic           adv;

  assign adv = (cnt_q != '0) | sel_any;

  always_comb begin
    cnt_d   = cnt_q;
    grant_d = grant_q;
    top_d   = top_q;
    if (cnt_q == '0) begin
      if (sel_any) begin
        grant_d = sel_oh;
        cnt_d   = CW'(XFER_CYCLES);
        top_d   = (sel_idx == IW'(NCH - 1)) ? '0 : sel_idx + 1'b1;
      end
    end else if (abort) begin
      grant_d = '0;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) grant_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      grant_q <= '0;
      top_q   <= '0;
    end else if (adv) begin
      cnt_q   <= cnt_d;
      grant_q <= grant_d;
      top_q   <= top_d;
    end
  end

  assign grant   = grant_q;
  assign top_idx = top_q;
  assign busy    = |grant_q;
endmodule

// File: rtl/dma_arb_vec.sv
module dma_arb_vec
  import dma_arb_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   done,
  input  logic [NCH-1:0]   ie,
  input  logic             gie,
  input  logic             busy,
  input  logic             vec_rd,
  output logic [NCH-1:0]   flags,
  output logic             irq,
  output logic [VEC_W-1:0] vec
);
  localparam int CDW = $clog2(NCH + 1);

  logic [NCH-1:0] flag_q, flag_d, pend, clr;
  logic [CDW-1:0] code;
  logic           upd;

  assign pend = flag_q & ie;

  always_comb begin
    code = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (pend[k]) code = CDW'(k + 1);
    end
  end

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      clr[k] = vec_rd && (code == CDW'(k + 1));
    end
    flag_d = (flag_q & ~clr) | done;
  end

  assign upd = vec_rd | (|done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= '0;
    else if (upd) flag_q <= flag_d;
  end

  assign flags = flag_q;
  assign irq   = gie & (|pend) & ~busy;
  assign vec   = VEC_W'(code) << VEC_LSB;
endmodule

// File: rtl/dma_arb_irq.sv
module dma_arb_irq
  import dma_arb_pkg::*;
#(
  parameter int NCH         = 3,
  parameter int XFER_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rr_en,
  input  logic [NCH-1:0]   ch_req,
  input  logic [NCH-1:0]   ch_done,
  input  logic [NCH-1:0]   ch_ie,
  input  logic             glb_ie,
  input  logic [NCH-1:0]   chain_sel,
  input  logic             vec_rd,
  input  logic             nmi_req,
  input  logic             nmi_en,
  output logic [NCH-1:0]   grant,
  output logic [NCH-1:0]   flag_out,
  output logic [NCH-1:0]   chain_trig,
  output logic             irq,
  output logic [VEC_W-1:0] vec_out,
  output logic             nmi_take
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] sel_oh;
  logic [IW-1:0]  sel_idx, top_idx;
  logic           sel_any, busy, abort;

  dma_arb_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .rr_en   (rr_en),
    .top_idx (top_idx),
    .req     (ch_req),
    .sel_oh  (sel_oh),
    .sel_idx (sel_idx),
    .sel_any (sel_any)
  );

  dma_arb_seq #(.NCH(NCH), .IW(IW), .XFER_CYCLES(XFER_CYCLES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_any (sel_any),
    .sel_oh  (sel_oh),
    .sel_idx (sel_idx),
    .abort   (abort),
    .grant   (grant),
    .top_idx (top_idx),
    .busy    (busy)
  );

  dma_arb_vec #(.NCH(NCH)) u_vec (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (ch_done),
    .ie     (ch_ie),
    .gie    (glb_ie),
    .busy   (busy),
    .vec_rd (vec_rd),
    .flags  (flag_out),
    .irq    (irq),
    .vec    (vec_out)
  );

  // Ring of chained triggers: each channel is fed by the flag of the one before it.
  for (genvar i = 0; i < NCH; i++) begin : g_chain
    assign chain_trig[i] = chain_sel[i] & flag_out[(i + NCH - 1) % NCH];
  end

  assign abort    = nmi_req & nmi_en & busy;
  assign nmi_take = nmi_req & (nmi_en | ~busy);
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ch_req,
  input logic [NCH-1:0] ch_done,
  input logic           vec_rd,
  input logic           nmi_req,
  input logic           nmi_en,
  input logic [NCH-1:0] grant,
  input logic [NCH-1:0] flag_out,
  input logic           irq,
  input logic [15:0]    vec_out,
  input logic           nmi_take
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R1

  AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|grant) |-> |(grant & $past(ch_req))); // R1

  AST_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant) && (|$past(grant))) |-> (grant == $past(grant))); // R4

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> !irq); // R6

  AST_VEC_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_out[15:4] == '0) && !vec_out[0] && (vec_out[3:1] <= 3'(NCH))); // R7

  AST_NMI_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |-> (nmi_en || (grant == '0))); // R10

  AST_NMI_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant) && nmi_req && nmi_en) |=> (grant == '0)); // R10

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ch_done[i] |=> flag_out[i]); // R5

    AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_rd && (vec_out == 16'(2 * (i + 1))) && !ch_done[i]) |=> !flag_out[i]); // R8
  end
endmodule

bind dma_arb_irq dma_arb_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ch_req   (ch_req),
  .ch_done  (ch_done),
  .vec_rd   (vec_rd),
  .nmi_req  (nmi_req),
  .nmi_en   (nmi_en),
  .grant    (grant),
  .flag_out (flag_out),
  .irq      (irq),
  .vec_out  (vec_out),
  .nmi_take (nmi_take)
);

// File: tb/dma_arb_irq_test.sv
`timescale 1ns/1ps
module dma_arb_irq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rr_en, glb_ie, vec_rd, nmi_req, nmi_en;
  logic [2:0]  ch_req, ch_done, ch_ie, chain_sel;
  logic [2:0]  grant, flag_out, chain_trig;
  logic        irq, nmi_take;
  logic [15:0] vec_out;
  int          n_chk = 0;
  int          n_err = 0;

  dma_arb_irq uut (
    .clk(clk), .rst_n(rst_n), .rr_en(rr_en), .ch_req(ch_req), .ch_done(ch_done),
    .ch_ie(ch_ie), .glb_ie(glb_ie), .chain_sel(chain_sel), .vec_rd(vec_rd),
    .nmi_req(nmi_req), .nmi_en(nmi_en), .grant(grant), .flag_out(flag_out),
    .chain_trig(chain_trig), .irq(irq), .vec_out(vec_out), .nmi_take(nmi_take)
  );

  always #10 clk = ~clk;

  // {rr_en, request mask, expected grant}; rotation state carries between rows.
  localparam logic [6:0] TBL [15] = '{
    {1'b0, 3'b111, 3'b001}, {1'b0, 3'b110, 3'b010}, {1'b0, 3'b101, 3'b001},
    {1'b0, 3'b100, 3'b100}, {1'b1, 3'b111, 3'b001}, {1'b1, 3'b111, 3'b010},
    {1'b1, 3'b111, 3'b100}, {1'b1, 3'b101, 3'b001}, {1'b1, 3'b101, 3'b100},
    {1'b1, 3'b110, 3'b010}, {1'b1, 3'b011, 3'b001}, {1'b0, 3'b010, 3'b010},
    {1'b1, 3'b001, 3'b001}, {1'b1, 3'b000, 3'b000}, {1'b1, 3'b110, 3'b010}
  };

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rr_en = 1'b0; glb_ie = 1'b0; vec_rd = 1'b0; nmi_req = 1'b0;
    nmi_en = 1'b0; ch_req = '0; ch_done = '0; ch_ie = '0; chain_sel = '0;
    repeat (3) @(posedge clk);
    #5;
    chk("R11 grant in reset", 16'(grant), 16'h0);
    chk("R11 flags in reset", 16'(flag_out), 16'h0);
    chk("R11 chain in reset", 16'(chain_trig), 16'h0);
    chk("R11 irq in reset", 16'(irq), 16'h0);
    chk("R11 vector in reset", vec_out, 16'h0);
    rst_n = 1'b1;
    tick();

    // R1 R2 R3: arbitration table
    for (int i = 0; i < 15; i++) begin
      rr_en  = TBL[i][6];
      ch_req = TBL[i][5:3];
      tick();
      chk($sformatf("R2/R3 row %0d grant", i), 16'(grant), 16'(TBL[i][2:0]));
      ch_req = '0;
      tick();
      chk($sformatf("R1 row %0d grant held", i), 16'(grant), 16'(TBL[i][2:0]));
      tick();
      chk($sformatf("R4 row %0d grant released", i), 16'(grant), 16'h0);
    end
    rr_en = 1'b0;

    // R4: back-to-back requests leave one idle cycle
    ch_req = 3'b001;
    tick(); chk("R4 first grant", 16'(grant), 16'h1);
    tick(); chk("R4 second cycle", 16'(grant), 16'h1);
    tick(); chk("R4 idle gap", 16'(grant), 16'h0);
    tick(); chk("R4 regrant after gap", 16'(grant), 16'h1);
    ch_req = '0;
    tick(); tick();

    // R1: new higher-priority request mid-transfer does not move the grant
    ch_req = 3'b100;
    tick(); chk("R1 grant ch2", 16'(grant), 16'h4);
    ch_req = 3'b111;
    tick(); chk("R1 no switch mid-transfer", 16'(grant), 16'h4);
    tick(); chk("R1 gap", 16'(grant), 16'h0);
    tick(); chk("R2 fixed picks ch0", 16'(grant), 16'h1);
    ch_req = '0;
    tick(); tick();

    // R5 R6 R7 R9: flags, vector, chaining
    ch_ie = 3'b111; glb_ie = 1'b1; chain_sel = 3'b111;
    ch_done = 3'b110;
    tick();
    ch_done = '0;
    chk("R5 flags set", 16'(flag_out), 16'h6);
    chk("R7 vector ch1", vec_out, 16'h4);
    chk("R6 irq raised", 16'(irq), 16'h1);
    chk("R9 chain ring", 16'(chain_trig), 16'h5);
    tick();
    chk("R9 flags kept", 16'(flag_out), 16'h6);
    ch_ie = 3'b011; #1; chk("R7 masked vector", vec_out, 16'h4);
    ch_ie = 3'b100; #1; chk("R7 vector ch2", vec_out, 16'h6);
    ch_ie = 3'b000; #1;
    chk("R7 vector none", vec_out, 16'h0);
    chk("R6 irq masked", 16'(irq), 16'h0);
    ch_ie = 3'b111; glb_ie = 1'b0; #1;
    chk("R6 irq global off", 16'(irq), 16'h0);
    chk("R7 vector ignores global", vec_out, 16'h4);
    glb_ie = 1'b1;

    // R8: read clears only the reported flag
    vec_rd = 1'b1; tick(); vec_rd = 1'b0;
    chk("R8 read clears ch1", 16'(flag_out), 16'h4);
    chk("R7 next vector", vec_out, 16'h6);
    chk("R9 chain after clear", 16'(chain_trig), 16'h1);

    // R5: set beats clear
    vec_rd = 1'b1; ch_done = 3'b100; tick(); vec_rd = 1'b0; ch_done = '0;
    chk("R5 set wins over clear", 16'(flag_out), 16'h4);
    vec_rd = 1'b1; tick(); vec_rd = 1'b0;
    chk("R8 last flag cleared", 16'(flag_out), 16'h0);
    chk("R7 empty vector", vec_out, 16'h0);

    // R8: read of an empty vector changes nothing
    ch_ie = 3'b000; ch_done = 3'b001; tick(); ch_done = '0;
    vec_rd = 1'b1; tick(); vec_rd = 1'b0;
    chk("R8 empty read keeps flag", 16'(flag_out), 16'h1);
    ch_ie = 3'b111; #1;
    chk("R7 vector ch0", vec_out, 16'h2);

    // R6: irq held low during a transfer
    ch_req = 3'b010;
    tick(); chk("R6 irq low while busy", 16'(irq), 16'h0);
    ch_req = '0;
    tick(); chk("R6 irq still low", 16'(irq), 16'h0);
    tick(); chk("R6 irq back after transfer", 16'(irq), 16'h1);
    vec_rd = 1'b1; tick(); vec_rd = 1'b0;

    // R10: non-maskable event handling
    nmi_req = 1'b1; nmi_en = 1'b0; #1;
    chk("R10 take when idle", 16'(nmi_take), 16'h1);
    ch_req = 3'b001;
    tick(); chk("R10 held off while busy", 16'(nmi_take), 16'h0);
    ch_req = '0;
    tick(); chk("R10 transfer not cut", 16'(grant), 16'h1);
    tick();
    nmi_en = 1'b0; nmi_req = 1'b0;
    ch_req = 3'b001;
    tick();
    nmi_req = 1'b1; nmi_en = 1'b1; ch_req = '0; #1;
    chk("R10 take when enabled", 16'(nmi_take), 16'h1);
    tick(); chk("R10 abort drops grant", 16'(grant), 16'h0);
    nmi_req = 1'b0; nmi_en = 1'b0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule